// File: doc/BRIEF.md
# GPIO Bank Interrupt Controller

This block turns the 32 input pins of one GPIO bank into a single bank interrupt. Every pin passes through a two-flop synchroniser. A per-pin trigger selection then decides whether the pin raises a pending bit. A pin can trigger on a level (high or low) or on an edge (rising, falling, or both). Pending bits are kept per pin. A per-pin mask decides which pending bits reach the bank interrupt line.

Software reaches the block through a single-beat register port: a write strobe, an address, write data, and a read data bus that is registered one cycle after the address. Unmasking and masking go through two separate write-one-to-set registers that both act on one mask register. Pending bits are cleared by writing ones to the status register.

Top module: `gpio_irq_bank`

## Requirements
- R1: Writing to address 1 (unmask) clears the mask bit of every pin whose write bit is 1. Pins whose write bit is 0 keep their mask bit.
- R2: Writing to address 2 (mask) sets the mask bit of every pin whose write bit is 1. Pins whose write bit is 0 keep their mask bit.
- R3: Reading address 0 returns the mask, with 1 meaning masked. After reset the mask reads all ones, the kind, polarity and both-edge registers (addresses 4, 5, 6) read zero, and the interrupt output is low. Read data appears in the cycle after the address is presented.
- R4: Address 3 reads the pending bits. Writing a 1 to a bit clears that bit. Writing a 0 leaves the bit unchanged.
- R5: A pin whose kind bit (address 4) is 1 is edge triggered. Its pending bit is set by a qualifying edge on the synchronised input and stays set until it is cleared.
- R6: For an edge pin whose both-edge bit is 0, polarity bit 1 (address 5) selects the rising edge and polarity bit 0 selects the falling edge.
- R7: For an edge pin, a both-edge bit (address 6) of 1 makes it trigger on either edge whatever its polarity. The both-edge bit has no effect on a level pin.
- R8: A pin whose kind bit is 0 is level triggered. Its pending bit follows the synchronised input being at the active level: high when polarity is 1, low when polarity is 0. Clearing it has no lasting effect while the level stays active.
- R9: The bank interrupt output is registered. It is high in the cycle after any pending bit is set on an unmasked pin, and low in the cycle after no such bit exists.
- R10: If a new edge event and a write-one-to-clear reach the same pending bit in the same cycle, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data for the address of the previous cycle |
| pins_in | input | 32 | Asynchronous bank pin inputs |
| bank_irq | output | 1 | Bank interrupt, OR of unmasked pending bits |

## Verification
Two functions can act on the same pending bit in one cycle: edge detection setting it, and a write-one-to-clear to the status register. The bench counts the synchroniser and detector registers from the moment a pin toggles. It then places the clear write exactly on the clock edge at which the edge event is latched, on a bit that is already pending. The bit must read back as set afterwards. A later clear with no edge present must then empty it, which shows the write itself did take effect.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    REG_MASK    = 3'd0,
    REG_UNMASK  = 3'd1,
    REG_MASKSET = 3'd2,
    REG_PEND    = 3'd3,
    REG_KIND    = 3'd4,
    REG_POL     = 3'd5,
    REG_BOTH    = 3'd6
  } reg_sel_e;
endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] cur,
  output logic [W-1:0] prev
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= '0;
      prev <= '0;
    end else begin
      chain[0] <= d;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
      prev <= chain[STAGES-1];
    end
  end

  assign cur = chain[STAGES-1];
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
  parameter int W = 32
) (
  input  logic [W-1:0] cur,
  input  logic [W-1:0] prev,
  input  logic [W-1:0] kind,
  input  logic [W-1:0] pol,
  input  logic [W-1:0] both,
  output logic [W-1:0] set_vec
);
  for (genvar g = 0; g < W; g++) begin : g_pin
    logic rise, fall, edge_hit, lvl_hit;
    assign rise     = cur[g] & ~prev[g];
    assign fall     = ~cur[g] & prev[g];
    assign edge_hit = both[g] ? (rise | fall) : (pol[g] ? rise : fall);
    assign lvl_hit  = pol[g] ? cur[g] : ~cur[g];
    assign set_vec[g] = kind[g] ? edge_hit : lvl_hit;
  end
endmodule

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
  import gpio_irq_pkg::*;
#(
  parameter int W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [W-1:0]      wdata,
  input  logic [W-1:0]      set_vec,
  output logic [W-1:0]      rdata,
  output logic [W-1:0]      mask_q,
  output logic [W-1:0]      status_q,
  output logic [W-1:0]      kind_q,
  output logic [W-1:0]      pol_q,
  output logic [W-1:0]      both_q
);
  reg_sel_e     sel;
  logic [W-1:0] clr;

  assign sel = reg_sel_e'(addr);
  assign clr = (wr && sel == REG_PEND) ? wdata : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q   <= '1;
      status_q <= '0;
      kind_q   <= '0;
      pol_q    <= '0;
      both_q   <= '0;
      rdata    <= '0;
    end else begin
      if (wr) begin
        case (sel)
          REG_UNMASK:  mask_q <= mask_q & ~wdata;
          REG_MASKSET: mask_q <= mask_q | wdata;
          REG_KIND:    kind_q <= wdata;
          REG_POL:     pol_q  <= wdata;
          REG_BOTH:    both_q <= wdata;
          default: ;
        endcase
      end
      // edge pins: sticky, set beats clear; level pins: live level
      status_q <= (kind_q & ((status_q & ~clr) | set_vec)) | (~kind_q & set_vec);
      case (sel)
        REG_MASK: rdata <= mask_q;
        REG_PEND: rdata <= status_q;
        REG_KIND: rdata <= kind_q;
        REG_POL:  rdata <= pol_q;
        REG_BOTH: rdata <= both_q;
        default:  rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank #(
  parameter int PINS        = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            reg_wr,
  input  logic [gpio_irq_pkg::ADDR_W-1:0] reg_addr,
  input  logic [PINS-1:0]                 reg_wdata,
  output logic [PINS-1:0]                 reg_rdata,
  input  logic [PINS-1:0]                 pins_in,
  output logic                            bank_irq
);
  logic [PINS-1:0] cur, prev, set_vec;
  logic [PINS-1:0] mask_q, status_q, kind_q, pol_q, both_q;

  gpio_irq_sync #(.W(PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(pins_in), .cur(cur), .prev(prev)
  );

  gpio_irq_detect #(.W(PINS)) u_detect (
    .cur(cur), .prev(prev), .kind(kind_q), .pol(pol_q), .both(both_q),
    .set_vec(set_vec)
  );

  gpio_irq_regs #(.W(PINS)) u_regs (
    .clk(clk), .rst(rst), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .set_vec(set_vec), .rdata(reg_rdata), .mask_q(mask_q),
    .status_q(status_q), .kind_q(kind_q), .pol_q(pol_q), .both_q(both_q)
  );

  always_ff @(posedge clk) begin
    if (rst) bank_irq <= 1'b0;
    else     bank_irq <= |(status_q & ~mask_q);
  end
endmodule

// File: rtl/gpio_irq_bank_chk.sv
module gpio_irq_bank_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst,
  input logic         reg_wr,
  input logic [2:0]   reg_addr,
  input logic [W-1:0] reg_wdata,
  input logic [W-1:0] mask_q,
  input logic [W-1:0] status_q,
  input logic [W-1:0] set_vec,
  input logic         bank_irq
);
  assert_unmask_R1: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == 3'd1) |=> ((mask_q & $past(reg_wdata)) == '0));

  assert_unmask_keep_R1: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == 3'd1) |=>
      ((mask_q & ~$past(reg_wdata)) == ($past(mask_q) & ~$past(reg_wdata))));

  assert_maskset_R2: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == 3'd2) |=> ((mask_q & $past(reg_wdata)) == $past(reg_wdata)));

  assert_reset_mask_R3: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (mask_q == '1 && status_q == '0 && !bank_irq));

  assert_w1c_R4: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == 3'd3) |=>
      ((status_q & $past(reg_wdata) & ~$past(set_vec)) == '0));

  assert_set_wins_R10: assert property (@(posedge clk) disable iff (rst)
    (set_vec != '0) |=> ((status_q & $past(set_vec)) == $past(set_vec)));

  assert_irq_on_R9: assert property (@(posedge clk) disable iff (rst)
    ((status_q & ~mask_q) != '0) |=> bank_irq);

  assert_irq_off_R9: assert property (@(posedge clk) disable iff (rst)
    ((status_q & ~mask_q) == '0) |=> !bank_irq);
endmodule

bind gpio_irq_bank gpio_irq_bank_chk #(.W(PINS)) u_chk (
  .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .mask_q(mask_q), .status_q(status_q),
  .set_vec(set_vec), .bank_irq(bank_irq)
);

// File: tb/test_gpio_irq_bank.sv
`timescale 1ns/1ps
module test_gpio_irq_bank;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = 3'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [31:0] pins_in = '0;
  logic        bank_irq;
  int nvec = 0;
  int nfail = 0;

  always #5 clk = ~clk;

  gpio_irq_bank i_gpio_irq_bank (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pins_in(pins_in),
    .bank_irq(bank_irq)
  );

  // {kind, pol, both, pins_start, pins_end, expected_pending} in low byte
  localparam logic [47:0] VEC [7] = '{
    48'hFF_FF_00_0F_F0_F0,
    48'hFF_00_00_0F_F0_0F,
    48'hFF_00_FF_0F_F0_FF,
    48'h00_FF_FF_0F_F0_F0,
    48'h00_00_00_0F_F0_0F,
    48'hF0_CC_30_AA_55_76,
    48'hFF_FF_00_F0_F0_00
  };

  function automatic string vec_req(int i);
    case (i)
      0, 1:    return "R6";
      2, 3:    return "R7";
      4:       return "R8";
      default: return "R5";
    endcase
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic settle();
    repeat (6) @(negedge clk);
  endtask

  initial begin
    #1_000_000;
    nfail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    logic [31:0] r;
    pins_in = 32'hFFFF_FFFF;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R3: reset state
    check("R3 irq", {31'd0, bank_irq}, 32'd0);
    rd(3'd0, r); check("R3 mask", r, 32'hFFFF_FFFF);
    rd(3'd4, r); check("R3 kind", r, 32'd0);
    rd(3'd5, r); check("R3 pol", r, 32'd0);
    rd(3'd6, r); check("R3 both", r, 32'd0);
    // R1 / R2: set-only mask updates
    wr(3'd1, 32'h0000_000F); rd(3'd0, r); check("R1 unmask", r, 32'hFFFF_FFF0);
    wr(3'd1, 32'h0000_0030); rd(3'd0, r); check("R1 keep", r, 32'hFFFF_FFC0);
    wr(3'd2, 32'h0000_0001); rd(3'd0, r); check("R2 mask", r, 32'hFFFF_FFC1);
    wr(3'd1, 32'hFFFF_FFFF);

    // vector table
    for (int i = 0; i < 7; i++) begin
      logic [7:0] t, p, a, s, e, x;
      {t, p, a, s, e, x} = VEC[i];
      wr(3'd4, {24'hFF_FFFF, t});
      wr(3'd5, {24'h0, p});
      wr(3'd6, {24'h0, a});
      pins_in = {24'h0, s};
      settle();
      wr(3'd3, 32'hFFFF_FFFF);
      pins_in = {24'h0, e};
      settle();
      rd(3'd3, r);
      check(vec_req(i), r, {24'h0, x});
      check("R9 irq", {31'd0, bank_irq}, {31'd0, (x != 8'h00)});
    end

    // R4 / R5: partial clear and stickiness
    wr(3'd4, 32'hFFFF_FFFF); wr(3'd5, 32'hFFFF_FFFF); wr(3'd6, 32'h0);
    pins_in = '0; settle(); wr(3'd3, 32'hFFFF_FFFF);
    pins_in = 32'h3; settle();
    rd(3'd3, r); check("R5 rise", r, 32'h3);
    wr(3'd3, 32'h1); rd(3'd3, r); check("R4 partial clear", r, 32'h2);
    pins_in = '0; settle();
    rd(3'd3, r); check("R5 sticky", r, 32'h2);

    // R9: masking gates the output
    wr(3'd2, 32'h2); repeat (2) @(negedge clk);
    check("R9 masked", {31'd0, bank_irq}, 32'd0);
    wr(3'd1, 32'h2); repeat (2) @(negedge clk);
    check("R9 unmasked", {31'd0, bank_irq}, 32'd1);
    wr(3'd3, 32'hFFFF_FFFF); repeat (2) @(negedge clk);
    check("R9 cleared", {31'd0, bank_irq}, 32'd0);

    // R8: level pin clear does not hold
    wr(3'd4, 32'hFFFF_FFFE);
    pins_in = 32'h1; settle();
    wr(3'd3, 32'h1); rd(3'd3, r); check("R8 level held", r & 32'h1, 32'h1);
    pins_in = '0; settle();
    rd(3'd3, r); check("R8 level follows", r & 32'h1, 32'h0);

    // R10: edge and clear in the same cycle
    wr(3'd4, 32'hFFFF_FFFF);
    settle(); wr(3'd3, 32'hFFFF_FFFF);
    pins_in = 32'h1; settle();
    pins_in = '0; settle();
    rd(3'd3, r); check("R10 pre-pending", r, 32'h1);
    @(negedge clk); pins_in = 32'h1;
    @(negedge clk);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 3'd3; reg_wdata = 32'h1;
    @(negedge clk);
    reg_wr = 1'b0;
    rd(3'd3, r); check("R10 set wins", r, 32'h1);
    wr(3'd3, 32'h1); rd(3'd3, r); check("R4 clear no edge", r, 32'h0);

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule